// File: doc/BRIEF.md
# PS/2 Device-Side Byte Transmitter with Chunk Retransmission

This block is the sending half of a keyboard- or mouse-style peripheral on a two-wire open-collector bus. Upstream logic pushes bytes into a 16-entry queue and marks the final byte of each logical group (a "chunk", such as a multi-byte break code or a movement packet). The block generates the bus clock itself and shifts each byte out as an 11-bit frame. It releases or pulls low the clock and data wires through two active-high pull-low outputs.

The host may hold the clock wire low at any moment to stop the device. Before each frame the block waits for the clock wire to stay high for a programmable idle span. While a frame is running, it samples the clock wire at the middle of every high phase that it leaves released. A low level seen there is treated as a host inhibit. An inhibit on any of bits 1 to 10 abandons the frame and rewinds the queue to the first byte of the current chunk, so the whole chunk is sent again. An inhibit on bit 0 (before the first falling edge), or one that arrives after the eleventh falling edge, causes no retransmission.

All timing is counted in system clock cycles. With a 1 MHz system clock, the default phase of 40 cycles gives 40 µs per clock phase, and the default idle span of 50 cycles gives 50 µs.

Top module: `ps2_dev_tx`

## Requirements
- R1: A frame's start bit is driven only after the clock wire has been sensed high for at least IDLE_TICKS consecutive cycles.
- R2: While the host holds the clock wire low, no frame is begun and both pull-low outputs stay inactive. Queued bytes are kept and are sent after the wire is released.
- R3: Within a frame, every clock low phase the block drives lasts exactly HALF_TICKS cycles. Every released high phase between two of its falling edges also lasts HALF_TICKS cycles.
- R4: The data output changes only while the block's clock output is released. Inside a frame, a new bit appears HALF_TICKS/2 cycles (plus the synchronizer and register latency) after the clock was released.
- R5: Each frame carries, in the order of its falling edges: a 0 start bit, the 8 data bits least significant first, an odd parity bit (1 when the data byte has an even count of ones), and a 1 stop bit. The data wire is left released after the frame.
- R6: A host inhibit sampled in the high phase of bits 1 to 10 aborts the frame. Transmission then resumes from the first byte of the chunk that was in progress, so bytes of that chunk already delivered are sent again.
- R7: An inhibit sampled in the high phase of bit 0, or asserted after the eleventh falling edge, causes no byte to be sent twice.
- R8: The queue holds DEPTH (16) bytes, counted from the first byte of the oldest unfinished chunk. A push while it is full is dropped.
- R9: Bytes and chunks leave in the order they were pushed. A byte pushed with the end-of-chunk flag set closes its chunk.
- R10: After reset both pull-low outputs are inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Offers one byte this cycle |
| push_data | input | 8 | Byte offered |
| push_last | input | 1 | Byte offered is the final byte of its chunk |
| bus_clk_i | input | 1 | Sensed level of the bus clock wire |
| bus_clk_low | output | 1 | 1 pulls the bus clock wire low, 0 releases it |
| bus_dat_low | output | 1 | 1 pulls the bus data wire low, 0 releases it |

## Verification
The properties assume that the sensed clock wire is the wired-AND of the block's own clock output and the host's pull. They also assume that upstream logic never lets a chunk grow beyond the queue depth and never leaves a pushed chunk unterminated. The stimulus models the host as a pull that is held low for no less than twenty cycles, and it only drives that pull between clock edges. Every chunk the stimulus pushes is closed and fits in 16 bytes, except in the overflow scenario. There, single-byte chunks are pushed while the bus is held inhibited, so the extra bytes are the ones that get dropped. Each inhibit is placed by watching the decoded bit count on the wires, so that it falls within the high phase it targets.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

   localparam int FRAME_BITS = 11;
   localparam int BIT_W      = 4;

   typedef enum logic [1:0] {
      TX_WAIT = 2'd0,
      TX_HIGH = 2'd1,
      TX_LOW  = 2'd2
   } tx_state_e;

   typedef struct packed {
      logic       last;
      logic [7:0] data;
   } tx_entry_t;

   // frame bit 0 is the start bit, bit 10 the stop bit
   function automatic logic [FRAME_BITS-1:0] build_frame(input logic [7:0] d);
      return {1'b1, ~(^d), d, 1'b0};
   endfunction

endpackage

// File: rtl/ps2tx_sync.sv
module ps2tx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 0) begin : g_bad_stages
      $error("ps2tx_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r <= '1;
         end else begin
            for (int i = STAGES - 1; i > 0; i--) r[i] <= r[i-1];
            r[0] <= d;
         end
      end
      assign q = r[STAGES-1];
   end

endmodule

// File: rtl/ps2tx_idle_mon.sv
module ps2tx_idle_mon #(
   parameter int IDLE_TICKS = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_hi,
   output logic idle_ok
);

   localparam int CW = $clog2(IDLE_TICKS + 1);
   localparam logic [CW-1:0] SAT_V = CW'(IDLE_TICKS);

   if (IDLE_TICKS < 1) begin : g_bad_idle
      $error("ps2tx_idle_mon: IDLE_TICKS must be at least 1");
   end

   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (!line_hi) begin
         run_q <= '0;
      end else if (run_q != SAT_V) begin
         run_q <= run_q + 1'b1;
      end
   end

   assign idle_ok = (run_q == SAT_V);

endmodule

// File: rtl/ps2tx_fifo.sv
module ps2tx_fifo
   import ps2tx_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  tx_entry_t                    push_entry,
   input  logic                         advance,
   input  logic                         rewind,
   output logic                         avail,
   output tx_entry_t                    head,
   output logic [$clog2(DEPTH+1)-1:0]   fill
);

   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("ps2tx_fifo: DEPTH must be a power of two, at least 2");
   end

   tx_entry_t mem [DEPTH];
   logic [AW:0] wr_q, rd_q, cm_q;
   logic [AW:0] used;
   logic        accept;

   assign used   = wr_q - cm_q;
   assign accept = push && !used[AW];
   assign avail  = (rd_q != wr_q);
   assign head   = mem[rd_q[AW-1:0]];
   assign fill   = used;

   always_ff @(posedge clk) begin
      if (accept) mem[wr_q[AW-1:0]] <= push_entry;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= '0;
         rd_q <= '0;
         cm_q <= '0;
      end else begin
         if (accept) wr_q <= wr_q + 1'b1;
         if (rewind) begin
            rd_q <= cm_q;
         end else if (advance) begin
            rd_q <= rd_q + 1'b1;
            if (head.last) cm_q <= rd_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/ps2tx_framer.sv
module ps2tx_framer
   import ps2tx_pkg::*;
#(
   parameter int HALF_TICKS = 40,
   parameter int MID_TICKS  = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_hi,
   input  logic             idle_ok,
   input  logic             avail,
   input  logic [7:0]       head_data,
   output logic             clk_low,
   output logic             dat_low,
   output logic             advance,
   output logic             rewind,
   output logic [BIT_W-1:0] bit_idx
);

   localparam int TW = $clog2(HALF_TICKS);
   localparam logic [TW-1:0]    MID_V  = TW'(MID_TICKS);
   localparam logic [TW-1:0]    END_V  = TW'(HALF_TICKS - 1);
   localparam logic [BIT_W-1:0] STOP_V = BIT_W'(FRAME_BITS - 1);

   if (MID_TICKS < 1 || MID_TICKS >= HALF_TICKS - 1) begin : g_bad_mid
      $error("ps2tx_framer: MID_TICKS must lie inside the phase");
   end

   tx_state_e             state_q;
   logic [TW-1:0]         tick_q;
   logic [FRAME_BITS-1:0] frame_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TX_WAIT;
         tick_q  <= '0;
         bit_idx <= '0;
         frame_q <= '0;
         dat_low <= 1'b0;
         advance <= 1'b0;
         rewind  <= 1'b0;
      end else begin
         advance <= 1'b0;
         rewind  <= 1'b0;
         unique case (state_q)
            TX_WAIT: begin
               dat_low <= 1'b0;
               if (avail && idle_ok) begin
                  frame_q <= build_frame(head_data);
                  state_q <= TX_HIGH;
                  tick_q  <= '0;
                  bit_idx <= '0;
               end
            end
            TX_HIGH: begin
               tick_q <= tick_q + 1'b1;
               if (tick_q == MID_V) begin
                  if (!clk_hi) begin
                     dat_low <= 1'b0;
                     state_q <= TX_WAIT;
                     if (bit_idx != '0) rewind <= 1'b1;
                  end else begin
                     dat_low <= ~frame_q[bit_idx];
                  end
               end else if (tick_q == END_V) begin
                  state_q <= TX_LOW;
                  tick_q  <= '0;
               end
            end
            TX_LOW: begin
               tick_q <= tick_q + 1'b1;
               if (tick_q == END_V) begin
                  tick_q <= '0;
                  if (bit_idx == STOP_V) begin
                     dat_low <= 1'b0;
                     advance <= 1'b1;
                     state_q <= TX_WAIT;
                  end else begin
                     bit_idx <= bit_idx + 1'b1;
                     state_q <= TX_HIGH;
                  end
               end
            end
            default: state_q <= TX_WAIT;
         endcase
      end
   end

   assign clk_low = (state_q == TX_LOW);

endmodule

// File: rtl/ps2_dev_tx.sv
module ps2_dev_tx
   import ps2tx_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter int HALF_TICKS  = 40,
   parameter int IDLE_TICKS  = 50,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       push_valid,
   input  logic [7:0] push_data,
   input  logic       push_last,
   input  logic       bus_clk_i,
   output logic       bus_clk_low,
   output logic       bus_dat_low
);

   localparam int MID_TICKS = HALF_TICKS / 2;
   localparam int FILL_W    = $clog2(DEPTH + 1);

   if (MID_TICKS <= SYNC_STAGES + 1) begin : g_bad_phase
      $error("ps2_dev_tx: HALF_TICKS too short for the synchronizer");
   end

   logic              clk_hi;
   logic              idle_ok;
   logic              avail;
   logic              advance;
   logic              rewind;
   tx_entry_t         head;
   tx_entry_t         in_entry;
   logic [FILL_W-1:0] fifo_fill;
   logic [BIT_W-1:0]  frame_bit;

   assign in_entry = '{last: push_last, data: push_data};

   ps2tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n(rst_n), .d(bus_clk_i), .q(clk_hi)
   );

   ps2tx_idle_mon #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
      .clk(clk), .rst_n(rst_n), .line_hi(clk_hi), .idle_ok(idle_ok)
   );

   ps2tx_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_valid),
      .push_entry(in_entry),
      .advance   (advance),
      .rewind    (rewind),
      .avail     (avail),
      .head      (head),
      .fill      (fifo_fill)
   );

   ps2tx_framer #(.HALF_TICKS(HALF_TICKS), .MID_TICKS(MID_TICKS)) u_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clk_hi   (clk_hi),
      .idle_ok  (idle_ok),
      .avail    (avail),
      .head_data(head.data),
      .clk_low  (bus_clk_low),
      .dat_low  (bus_dat_low),
      .advance  (advance),
      .rewind   (rewind),
      .bit_idx  (frame_bit)
   );

endmodule

// File: rtl/ps2_dev_tx_chk.sv
module ps2_dev_tx_chk #(
   parameter int DEPTH      = 16,
   parameter int HALF_TICKS = 40,
   parameter int IDLE_TICKS = 50
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         bus_clk_i,
   input logic                         bus_clk_low,
   input logic                         bus_dat_low,
   input logic [$clog2(DEPTH+1)-1:0]   fill,
   input logic [3:0]                   bit_idx
);

   localparam int FW = $clog2(DEPTH + 1);
   localparam int LW = $clog2(HALF_TICKS + 2);
   localparam int IW = $clog2(IDLE_TICKS + 1);
   localparam logic [FW-1:0] DEPTH_V = FW'(DEPTH);
   localparam logic [LW-1:0] HALF_V  = LW'(HALF_TICKS);
   localparam logic [IW-1:0] IDLE_V  = IW'(IDLE_TICKS);

   logic [LW-1:0] lo_cnt;
   logic [IW-1:0] hi_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_cnt <= '0;
         hi_run <= '0;
      end else begin
         lo_cnt <= bus_clk_low ? lo_cnt + 1'b1 : '0;
         if (!bus_clk_i)            hi_run <= '0;
         else if (hi_run != IDLE_V) hi_run <= hi_run + 1'b1;
      end
   end

   // R1: the start bit follows an idle span of the clock wire
   a_r1_idle_before_start: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bus_dat_low) && bit_idx == 4'd0) |-> (hi_run == IDLE_V));

   // R3: every driven low phase has its full length
   a_r3_low_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_clk_low) |-> (lo_cnt == HALF_V));

   // R4: data moves only while the clock output is released
   a_r4_data_in_high: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_dat_low != $past(bus_dat_low)) |-> (!bus_clk_low && !$past(bus_clk_low)));

   // R8: occupancy never exceeds the depth
   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= DEPTH_V);

endmodule

bind ps2_dev_tx ps2_dev_tx_chk #(
   .DEPTH(DEPTH), .HALF_TICKS(HALF_TICKS), .IDLE_TICKS(IDLE_TICKS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_clk_i  (bus_clk_i),
   .bus_clk_low(bus_clk_low),
   .bus_dat_low(bus_dat_low),
   .fill       (fifo_fill),
   .bit_idx    (frame_bit)
);

// File: tb/ps2_dev_tx_test.sv
module ps2_dev_tx_test;

   localparam int CLK_PERIOD = 10;
   localparam int HALF = 40;
   localparam int IDLE = 50;
   localparam int MID  = HALF / 2;
   localparam int NVEC = 8;
   // {last, data, expected parity}
   localparam logic [9:0] VEC [NVEC] = '{
      {1'b1, 8'h15, 1'b0}, {1'b0, 8'hF0, 1'b1}, {1'b1, 8'h12, 1'b1},
      {1'b1, 8'h00, 1'b1}, {1'b0, 8'hFF, 1'b1}, {1'b0, 8'h80, 1'b0},
      {1'b1, 8'h07, 1'b0}, {1'b1, 8'hA5, 1'b1}
   };

   logic clk = 0, rst_n = 0;
   logic push_valid = 0, push_last = 0, host_low = 0;
   logic [7:0] push_data = 0;
   logic bus_clk_low, bus_dat_low, line_clk, line_dat;

   assign line_clk = !(bus_clk_low || host_low);
   assign line_dat = !bus_dat_low;

   ps2_dev_tx uut (
      .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
      .push_last(push_last), .bus_clk_i(line_clk),
      .bus_clk_low(bus_clk_low), .bus_dat_low(bus_dat_low)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   logic [7:0] rx_q [256];
   logic       rx_par [256];
   int rx_n = 0, rx_bits = 0, hi_run = 0, lo_run = 0;
   int phase_err = 0, data_err = 0, fmt_err = 0, idle_err = 0;
   logic [10:0] rx_sh = '0;
   logic prev_clk = 1, prev_dat = 1, inh_low = 0;
   logic [7:0] exp_q [64];
   int exp_n = 0;

   // bus receiver, sampled mid-cycle
   always @(negedge clk) begin
      if (rst_n) begin
         if (host_low) begin
            rx_bits = 0;
         end else if (prev_clk && !line_clk) begin
            if (rx_bits >= 1 && rx_bits <= 10 && hi_run != HALF) phase_err++;
            if (rx_bits == 0 && hi_run < IDLE) idle_err++;
            rx_sh[rx_bits] = line_dat;
            rx_bits++;
            if (rx_bits == 11) begin
               if (rx_sh[0] != 1'b0 || rx_sh[10] != 1'b1 || (^rx_sh[9:1]) != 1'b1) fmt_err++;
               rx_q[rx_n] = rx_sh[8:1];
               rx_par[rx_n] = rx_sh[9];
               rx_n++;
               rx_bits = 0;
            end
         end
         if (!prev_clk && line_clk) begin
            if (!inh_low && lo_run != HALF) phase_err++;
            inh_low = 0;
         end
         if (line_dat != prev_dat) begin
            if (!line_clk && !host_low) data_err++;
            else if (line_clk && rx_bits > 0 && (hi_run < MID || hi_run > MID + 3)) data_err++;
         end
         if (!line_clk && host_low) inh_low = 1;
         hi_run = line_clk ? hi_run + 1 : 0;
         lo_run = line_clk ? 0 : lo_run + 1;
         prev_clk = line_clk;
         prev_dat = line_dat;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] d, input logic last);
      @(posedge clk); #1;
      push_valid = 1; push_data = d; push_last = last;
      @(posedge clk); #1;
      push_valid = 0;
   endtask

   task automatic set_host(input logic v);
      @(posedge clk); #1;
      host_low = v;
   endtask

   task automatic wait_rx(input int target, input string req);
      int guard = 0;
      while (rx_n < target && guard < 30000) begin
         @(posedge clk);
         guard++;
      end
      chk(rx_n >= target, req, rx_n, target);
   endtask

   task automatic compare_stream(input int base, input string req);
      repeat (2500) @(posedge clk);
      chk(rx_n - base == exp_n, req, rx_n - base, exp_n);
      for (int i = 0; i < exp_n && i < rx_n - base; i++)
         chk(rx_q[base + i] == exp_q[i], req, rx_q[base + i], exp_q[i]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int base;
      repeat (3) @(posedge clk);
      #1;
      chk(bus_clk_low == 0, "R10 clock released in reset", bus_clk_low, 0);
      chk(bus_dat_low == 0, "R10 data released in reset", bus_dat_low, 0);
      rst_n = 1;
      repeat (5) @(posedge clk); #1;
      chk(bus_clk_low == 0 && bus_dat_low == 0, "R10 lines idle after reset",
          {bus_clk_low, bus_dat_low}, 0);

      // table walk: R5 format and parity, R9 ordering
      base = rx_n;
      for (int i = 0; i < NVEC; i++) push(VEC[i][8:1], VEC[i][9]);
      wait_rx(base + NVEC, "R9 table bytes delivered");
      for (int i = 0; i < NVEC; i++) begin
         chk(rx_q[base + i] == VEC[i][8:1], "R9 table byte order", rx_q[base + i], VEC[i][8:1]);
         chk(rx_par[base + i] == VEC[i][0], "R5 odd parity bit", rx_par[base + i], VEC[i][0]);
      end

      // R6: inhibit in mid second byte resends whole chunk
      base = rx_n;
      exp_n = 3; exp_q[0] = 8'h5A; exp_q[1] = 8'h5A; exp_q[2] = 8'hC3;
      push(8'h5A, 0); push(8'hC3, 1);
      wait_rx(base + 1, "R6 first byte of chunk");
      while (rx_bits < 5) @(posedge clk);
      set_host(1);
      repeat (3 * HALF) @(posedge clk);
      set_host(0);
      wait_rx(base + 3, "R6 chunk resent");
      compare_stream(base, "R6 rewind to chunk start");

      // R7: inhibit during bit 0 high phase holds without rewind
      base = rx_n;
      exp_n = 2; exp_q[0] = 8'h11; exp_q[1] = 8'h22;
      push(8'h11, 0); push(8'h22, 1);
      wait_rx(base + 1, "R7 first byte before bit0 inhibit");
      while (!line_clk) @(posedge clk);
      repeat (IDLE + 8) @(posedge clk);
      #1 host_low = 1;
      repeat (20) @(posedge clk);
      #1 host_low = 0;
      wait_rx(base + 2, "R7 second byte after bit0 inhibit");
      compare_stream(base, "R7 bit0 inhibit no resend");

      // R7: inhibit after the last falling edge
      base = rx_n;
      exp_n = 2; exp_q[0] = 8'h33; exp_q[1] = 8'h44;
      push(8'h33, 0); push(8'h44, 1);
      wait_rx(base + 1, "R7 first byte before late inhibit");
      #1 host_low = 1;
      repeat (3 * HALF) @(posedge clk);
      #1 host_low = 0;
      wait_rx(base + 2, "R7 second byte after late inhibit");
      compare_stream(base, "R7 late inhibit no resend");

      // R2 hold while inhibited, R8 overflow drop
      base = rx_n;
      set_host(1);
      for (int i = 0; i < 20; i++) push(8'h60 + 8'(i), 1);
      repeat (3000) @(posedge clk);
      chk(rx_n == base, "R2 nothing sent while inhibited", rx_n - base, 0);
      chk(bus_clk_low == 0 && bus_dat_low == 0, "R2 lines released while inhibited",
          {bus_clk_low, bus_dat_low}, 0);
      set_host(0);
      exp_n = 16;
      for (int i = 0; i < 16; i++) exp_q[i] = 8'h60 + 8'(i);
      wait_rx(base + 16, "R2 buffered bytes sent after release");
      compare_stream(base, "R8 full buffer drops extra pushes");

      chk(phase_err == 0, "R3 phase lengths", phase_err, 0);
      chk(data_err == 0, "R4 data change timing", data_err, 0);
      chk(fmt_err == 0, "R5 start stop parity", fmt_err, 0);
      chk(idle_err == 0, "R1 idle before start", idle_err, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule